// File: doc/BRIEF.md
# Sliding-Window Ones Counter

This block watches a serial bit stream that arrives on two general-purpose input pins, one carrying data and one carrying a serial clock. Neither pin is related to the system clock. Both pins pass through a synchronizer into the system clock domain. Each rising edge of the serial clock captures one data bit. That bit is shifted into a fixed-length window, and the oldest bit in the window is discarded. The window therefore always holds the most recent `WIN_LEN` bits, in first-in first-out order.

The block keeps a running count of the ones inside the window. It does not recount the whole register on each bit. It adds the incoming bit and subtracts the bit that falls off the far end. The window contents and the count become visible together, marked by a single-cycle strobe. The serial clock must run slower than a quarter of the system clock, and the data level must be steady from one system cycle before each serial clock rise until the serial clock falls. Serial edges closer together than the synchronizer can resolve are not guaranteed to be captured. If the serial clock pin is high when reset is released, one bit is captured at once.

Top module: `sliding_ones_counter`

## Requirements
- R1: While `rst` is high at a system clock edge, the window becomes all zeros, the count becomes zero and `valid_o` is low after that edge.
- R2: Only a rising edge of the serial clock pin captures a bit. A falling edge, or a change on the data pin while the serial clock is low, leaves `valid_o` low and the window and count unchanged.
- R3: On a capture, window bit 0 takes the captured data bit, each bit i moves to bit i+1, and bit `WIN_LEN-1` is discarded. Bit 0 is always the most recent bit.
- R4: After every update, `ones_o` equals the number of ones in `window_o` and never exceeds `WIN_LEN`.
- R5: Each update changes the count by exactly (captured bit − discarded bit), which is -1, 0 or +1.
- R6: `valid_o` is high for exactly one system cycle per capture. It rises at the third system clock edge after the serial clock pin rises, and the window and count change only at that same edge.
- R7: After reset, while fewer than `WIN_LEN` bits have been captured, the discarded bit is zero, so the count equals the number of ones captured so far.
- R8: The data bit captured is the level on the data pin when the serial clock pin rises. Changing the data pin while the serial clock stays high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_pin | input | 1 | Asynchronous serial clock pin |
| ser_data_pin | input | 1 | Asynchronous serial data pin |
| window_o | output | WIN_LEN | Last WIN_LEN bits, bit 0 most recent |
| ones_o | output | CNT_W | Number of ones in the window |
| valid_o | output | 1 | One-cycle strobe when window and count update |

## Verification
The stream is driven with a leading mixed pattern that separates the fill phase, where nothing is evicted yet, from steady state. Long runs of ones and of zeros push the count to its ceiling and back to zero, which exposes any off-by-one error in the eviction. An alternating pattern holds the count steady while every bit moves, so a wrong shift direction shows up in the window. A long pseudo-random stretch exercises every add/subtract combination. Data toggles while the serial clock is high, idle falling edges, and a reset in the middle of the stream show that only rising edges capture data and that reset clears everything.

// File: rtl/swoc_pkg.sv
package swoc_pkg;

  // Levels of the two input pins carried together through the synchronizer.
  typedef struct packed {
    logic lvl_clk;
    logic lvl_data;
  } pin_pair_t;

  // Bits needed to hold a count from 0 to n inclusive.
  function automatic int unsigned count_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/swoc_sync.sv
module swoc_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/swoc_edge.sv
module swoc_edge (
  input  logic clk,
  input  logic rst,
  input  logic sclk_s,
  input  logic sdata_s,
  output logic rise_o,
  output logic bit_o
);

  logic sclk_q;

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk_s;
  end

  // Rising edge seen on the synchronized serial clock; data sampled in the same cycle.
  assign rise_o = sclk_s & ~sclk_q;
  assign bit_o  = sdata_s;

endmodule

// File: rtl/swoc_window.sv
module swoc_window #(
  parameter int unsigned WIN_LEN = 16,
  parameter int unsigned CNT_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_en,
  input  logic               bit_in,
  output logic [WIN_LEN-1:0] win_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               evict_o,
  output logic               upd_o
);

  logic [WIN_LEN-1:0] win_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               upd_q;

  // Incremental count: plus the entering bit, minus the leaving bit.
  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c,
                                                   input logic in_b,
                                                   input logic out_b);
    case ({in_b, out_b})
      2'b10:   return c + 1'b1;
      2'b01:   return c - 1'b1;
      default: return c;
    endcase
  endfunction

  assign evict_o = win_q[WIN_LEN-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '0;
      cnt_q <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= shift_en;
      if (shift_en) begin
        win_q <= {win_q[WIN_LEN-2:0], bit_in};
        cnt_q <= step_count(cnt_q, bit_in, evict_o);
      end
    end
  end

  assign win_o = win_q;
  assign cnt_o = cnt_q;
  assign upd_o = upd_q;

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (win_q == '0 && cnt_q == '0 && !upd_q));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> ($stable(win_q) && $stable(cnt_q)));

  assert_shift_R3: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (win_q[WIN_LEN-1:1] == $past(win_q[WIN_LEN-2:0]) && win_q[0] == $past(bit_in)));

  assert_popcount_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q == CNT_W'($countones(win_q)));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(WIN_LEN));

  assert_step_R5: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (cnt_q == $past(cnt_q) + CNT_W'($past(bit_in)) - CNT_W'($past(evict_o))));

endmodule

// File: rtl/sliding_ones_counter.sv
module sliding_ones_counter import swoc_pkg::*; #(
  parameter int unsigned WIN_LEN     = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = count_width(WIN_LEN)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ser_clk_pin,
  input  logic               ser_data_pin,
  output logic [WIN_LEN-1:0] window_o,
  output logic [CNT_W-1:0]   ones_o,
  output logic               valid_o
);

  pin_pair_t pins_raw;
  pin_pair_t pins_sync;
  logic      capture_evt;
  logic      captured_bit;
  logic      evicted_bit;

  assign pins_raw.lvl_clk  = ser_clk_pin;
  assign pins_raw.lvl_data = ser_data_pin;

  swoc_sync #(
    .WIDTH (($bits(pin_pair_t))),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async(pins_raw),
    .q_sync (pins_sync)
  );

  swoc_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .sclk_s (pins_sync.lvl_clk),
    .sdata_s(pins_sync.lvl_data),
    .rise_o (capture_evt),
    .bit_o  (captured_bit)
  );

  swoc_window #(
    .WIN_LEN(WIN_LEN),
    .CNT_W  (CNT_W)
  ) u_window (
    .clk     (clk),
    .rst     (rst),
    .shift_en(capture_evt),
    .bit_in  (captured_bit),
    .win_o   (window_o),
    .cnt_o   (ones_o),
    .evict_o (evicted_bit),
    .upd_o   (valid_o)
  );

  assert_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    capture_evt |=> (valid_o && !capture_evt));

  assert_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  assert_evict_value_R7: assert property (@(posedge clk) disable iff (rst)
    (capture_evt && evicted_bit) |=> (ones_o == $past(ones_o) + CNT_W'($past(captured_bit)) - 1'b1));

endmodule

// File: tb/tb_sliding_ones_counter.sv
module tb_sliding_ones_counter;

  localparam int unsigned N  = 16;
  localparam int unsigned CW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ser_clk = 1'b0;
  logic          ser_dat = 1'b0;
  logic [N-1:0]  window_o;
  logic [CW-1:0] ones_o;
  logic          valid_o;

  int checks = 0;
  int errors = 0;
  bit ref_q[$];
  bit done = 0;

  always #4 clk = ~clk;

  sliding_ones_counter #(.WIN_LEN(N)) dut (
    .clk         (clk),
    .rst         (rst),
    .ser_clk_pin (ser_clk),
    .ser_data_pin(ser_dat),
    .window_o    (window_o),
    .ones_o      (ones_o),
    .valid_o     (valid_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] ref_window();
    logic [N-1:0] w = '0;
    foreach (ref_q[i]) w[i] = ref_q[i];
    return w;
  endfunction

  function automatic int ref_ones();
    int n = 0;
    foreach (ref_q[i]) n += ref_q[i];
    return n;
  endfunction

  task automatic quiet_cycles(input int n, input logic [N-1:0] w, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(valid_o == 1'b0, req, valid_o, 0);
      chk(window_o == w, req, window_o, w);
    end
  endtask

  task automatic send_bit(input bit b);
    logic [N-1:0] old_w;
    int old_ones, evicted;
    bit filling;
    old_w    = ref_window();
    old_ones = ones_o;
    evicted  = (ref_q.size() == N) ? int'(ref_q[N-1]) : 0;
    filling  = ref_q.size() < N;
    @(negedge clk); ser_dat = b;
    @(negedge clk); ser_clk = 1'b1;
    quiet_cycles(2, old_w, "R6 latency");
    ref_q.push_front(b);
    if (ref_q.size() > N) void'(ref_q.pop_back());
    @(negedge clk);
    chk(valid_o == 1'b1, "R6 strobe", valid_o, 1);
    chk(window_o == ref_window(), "R3 window", window_o, ref_window());
    chk(ones_o == ref_ones(), "R4 count", ones_o, ref_ones());
    chk(int'(ones_o) - old_ones == int'(b) - evicted, "R5 step", int'(ones_o) - old_ones, int'(b) - evicted);
    if (filling) chk(ones_o == ref_ones(), "R7 fill", ones_o, ref_ones());
    @(negedge clk);
    chk(valid_o == 1'b0, "R6 one cycle", valid_o, 0);
    ser_dat = ~b;
    quiet_cycles(3, ref_window(), "R8 data change while high");
    ser_clk = 1'b0;
    quiet_cycles(3, ref_window(), "R2 falling edge");
    ser_dat = b;
    quiet_cycles(2, ref_window(), "R2 data change while low");
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(window_o == '0, "R1 window", window_o, 0);
    chk(ones_o == '0, "R1 count", ones_o, 0);
    chk(valid_o == 1'b0, "R1 valid", valid_o, 0);
    rst = 1'b0;
    ref_q.delete();
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    do_reset();
    // fill phase with mixed bits (R7)
    send_bit(1); send_bit(1); send_bit(0); send_bit(1); send_bit(0);
    for (int i = 0; i < 20; i++) send_bit(1);   // saturate at N (R4)
    for (int i = 0; i < 20; i++) send_bit(0);   // drain to zero
    for (int i = 0; i < 24; i++) send_bit(i[0]); // alternating
    for (int i = 0; i < 60; i++) begin          // pseudo-random
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send_bit(lfsr[0]);
    end
    do_reset();                                 // mid-stream reset (R1)
    for (int i = 0; i < 6; i++) send_bit(1);    // refill after reset (R7)
    done = 1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule